// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor whose procedures get fresh registers by rotating a window rather than by spilling to the stack. Software always sees 32 register indices. Eight of them are global and name the same storage from every window. The other 24 are reached through a current window pointer. Each window has eight private locals. Its eight ins are shared with the window above it, and its eight outs are shared with the window below it. As a result, values a caller places in its outs appear in the callee's ins after a save, with no copying.

A save strobe moves the pointer to the next window down (modulo the window count), and a restore strobe moves it back up. The block tracks how many caller windows are still resident. A save that would use the last free window raises a one-cycle overflow pulse, and a restore with no resident caller raises a one-cycle underflow pulse. In both cases the pointer stays put. The trap handler that spills or fills windows in memory lives outside this block. Two read ports are combinational, and the single write port takes effect at the clock edge.

Top module: `wrf_top`

## Requirements
- R1: Index 0 always reads as zero, and writes to index 0 are discarded.
- R2: Indices 1..7 are globals. A value written there reads back unchanged from every window.
- R3: Indices 16..23 are locals. Each window keeps its own eight locals, so writes in one window leave another window's locals untouched.
- R4: Indices 8..15 (outs) of a window are the same storage as indices 24..31 (ins) of the window entered by a save from it. Offset k of the outs maps to offset k of the ins.
- R5: A save moves the current window down by one, and a restore moves it up by one, both modulo 8. Starting from window 0, a save therefore reaches window 7.
- R6: A write issued in the same cycle as a save or restore uses the window in effect before the move.
- R7: A read of the register being written in the same cycle returns the old value.
- R8: Reset leaves zero caller windows resident. A save while 6 caller windows are resident is refused. The overflow output is high for exactly the following cycle, and the window does not move.
- R9: A restore while no caller window is resident is refused. The underflow output is high for exactly the following cycle, and the window does not move.
- R10: A save and a restore in the same cycle are both ignored: the window does not move and neither flag rises.
- R11: A synchronous active-high reset clears every register, selects window 0 and lowers both flags.
- R12: The two read ports are independent. Each returns the register its own index selects in the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| save_i | input | 1 | Enter a new window (call) |
| restore_i | input | 1 | Return to the caller window |
| ovf_o | output | 1 | Save refused, window file full (one-cycle pulse) |
| unf_o | output | 1 | Restore refused, no resident caller (one-cycle pulse) |

## Verification
The assertions take the save and restore strobes to be single-cycle requests that are sampled at every edge. A held strobe counts as a fresh request on each cycle, and the assertions predict the window move or flag for each of those cycles on that basis. They also assume that reset is applied before any strobe is trusted. The stimulus starts with reset high. It then issues strobes with a low random density, mixing single saves and restores with deliberate runs that reach the full and empty limits and with cycles that raise both strobes together. This keeps the sequence inside those assumptions while it walks the window pointer past the wrap point.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  // Register group selected by the two top bits of an architectural index
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } wrf_grp_e;

endpackage

// File: rtl/wrf_index_map.sv
module wrf_index_map
  import wrf_pkg::*;
#(
  parameter int GRP  = 8,
  parameter int NWIN = 8,
  parameter int IDXW = 5,
  parameter int CWPW = 3,
  parameter int PHW  = 8
) (
  input  logic [IDXW-1:0] arch_idx,
  input  logic [CWPW-1:0] cwp,
  output logic [PHW-1:0]  phys_idx
);

  localparam int OFFW = $clog2(GRP);

  wrf_grp_e         grp;
  logic [OFFW-1:0]  off;
  logic [CWPW-1:0]  win;
  logic             upper_half;

  assign grp = wrf_grp_e'(arch_idx[IDXW-1 -: 2]);
  assign off = arch_idx[OFFW-1:0];

  always_comb begin
    win        = cwp;
    upper_half = 1'b0;
    unique case (grp)
      GRP_OUT: begin
        win        = cwp - CWPW'(1);
        upper_half = 1'b1;
      end
      GRP_LOCAL: upper_half = 1'b0;
      GRP_IN:    upper_half = 1'b1;
      default:   upper_half = 1'b0;
    endcase
    if (grp == GRP_GLOBAL) begin
      phys_idx = PHW'(off);
    end else begin
      phys_idx = PHW'(GRP) + PHW'(win) * PHW'(2 * GRP)
               + (upper_half ? PHW'(GRP) : PHW'(0)) + PHW'(off);
    end
  end

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int XLEN = 32,
  parameter int PHYS = 136,
  parameter int PHW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PHW-1:0]  wa,
  input  logic [XLEN-1:0] wd,
  input  logic [PHW-1:0]  ra0,
  output logic [XLEN-1:0] rd0,
  input  logic [PHW-1:0]  ra1,
  output logic [XLEN-1:0] rd1
);

  logic [XLEN-1:0] mem [PHYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd0 = (ra0 == '0) ? '0 : mem[ra0];
  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];

  // R1: the zero slot must never receive a write from the port logic
  a_r1_no_zero_write: assert property (@(posedge clk) disable iff (rst)
    we |-> (wa != '0));

endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
  parameter int NWIN = 8,
  parameter int CWPW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_i,
  input  logic            restore_i,
  output logic [CWPW-1:0] cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);

  localparam int DW   = $clog2(NWIN);
  localparam int MAXC = NWIN - 2;

  logic [CWPW-1:0] cwp_q;
  logic [DW-1:0]   callers_q;
  logic            do_save, do_rest, full, empty;

  assign do_save = save_i & ~restore_i;
  assign do_rest = restore_i & ~save_i;
  assign full    = (callers_q == DW'(MAXC));
  assign empty   = (callers_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q     <= '0;
      callers_q <= '0;
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (do_save) begin
        if (full) begin
          ovf_o <= 1'b1;
        end else begin
          cwp_q     <= cwp_q - CWPW'(1);
          callers_q <= callers_q + DW'(1);
        end
      end else if (do_rest) begin
        if (empty) begin
          unf_o <= 1'b1;
        end else begin
          cwp_q     <= cwp_q + CWPW'(1);
          callers_q <= callers_q - DW'(1);
        end
      end
    end
  end

  assign cwp_o = cwp_q;

  a_r8_overflow_hold: assert property (@(posedge clk) disable iff (rst)
    (do_save && full) |=> (ovf_o && cwp_q == $past(cwp_q)));

  a_r9_underflow_hold: assert property (@(posedge clk) disable iff (rst)
    (do_rest && empty) |=> (unf_o && $stable(cwp_q)));

  a_r5_save_step: assert property (@(posedge clk) disable iff (rst)
    (do_save && !full) |=> (cwp_q == CWPW'($past(cwp_q) - CWPW'(1))));

  a_r5_restore_step: assert property (@(posedge clk) disable iff (rst)
    (do_rest && !empty) |=> (cwp_q == CWPW'($past(cwp_q) + CWPW'(1))));

  a_r10_both_ignored: assert property (@(posedge clk) disable iff (rst)
    (save_i && restore_i) |=> ($stable(cwp_q) && !ovf_o && !unf_o));

  a_r8_callers_bound: assert property (@(posedge clk) disable iff (rst)
    callers_q <= DW'(MAXC));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o));

endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
  parameter int XLEN = 32,
  parameter int NWIN = 8,
  parameter int GRP  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(GRP)+1:0]        rd_a_idx,
  output logic [XLEN-1:0]               rd_a_data,
  input  logic [$clog2(GRP)+1:0]        rd_b_idx,
  output logic [XLEN-1:0]               rd_b_data,
  input  logic                          wr_en,
  input  logic [$clog2(GRP)+1:0]        wr_idx,
  input  logic [XLEN-1:0]               wr_data,
  input  logic                          save_i,
  input  logic                          restore_i,
  output logic                          ovf_o,
  output logic                          unf_o
);

  localparam int IDXW   = $clog2(GRP) + 2;
  localparam int CWPW   = $clog2(NWIN);
  localparam int PHYS   = GRP + NWIN * 2 * GRP;
  localparam int PHW    = $clog2(PHYS);
  localparam int NPORTS = 3;

  logic [CWPW-1:0] cwp;
  logic [IDXW-1:0] map_in  [NPORTS];
  logic [PHW-1:0]  map_out [NPORTS];
  logic            wr_ok;

  assign map_in[0] = rd_a_idx;
  assign map_in[1] = rd_b_idx;
  assign map_in[2] = wr_idx;

  wrf_window_ctrl #(.NWIN(NWIN), .CWPW(CWPW)) u_ctrl (
    .clk(clk), .rst(rst), .save_i(save_i), .restore_i(restore_i),
    .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_map
    wrf_index_map #(
      .GRP(GRP), .NWIN(NWIN), .IDXW(IDXW), .CWPW(CWPW), .PHW(PHW)
    ) u_map (
      .arch_idx(map_in[g]), .cwp(cwp), .phys_idx(map_out[g])
    );
  end

  // Writes to index 0 are dropped; the write maps through the pre-move window
  assign wr_ok = wr_en && (wr_idx != '0);

  wrf_storage #(.XLEN(XLEN), .PHYS(PHYS), .PHW(PHW)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_ok), .wa(map_out[2]), .wd(wr_data),
    .ra0(map_out[0]), .rd0(rd_a_data),
    .ra1(map_out[1]), .rd1(rd_b_data)
  );

  a_r1_zero_read_a: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  a_r1_zero_read_b: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == '0) |-> (rd_b_data == '0));

endmodule

// File: tb/test_wrf_top.sv
`timescale 1ns/1ps
module test_wrf_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic        ovf_o, unf_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wrf_top i_wrf_top (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_i(save_i), .restore_i(restore_i),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // Behavioural reference: plain arrays per window, integer window number
  logic [31:0] m_glob [8];
  logic [31:0] m_loc  [8][8];
  logic [31:0] m_in   [8][8];
  int          m_win;
  int          m_depth;
  bit          m_ovf, m_unf;

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin
      m_glob[i] = '0;
      for (int j = 0; j < 8; j++) begin m_loc[i][j] = '0; m_in[i][j] = '0; end
    end
    m_win = 0; m_depth = 0; m_ovf = 0; m_unf = 0;
  endtask

  function automatic logic [31:0] model_rd(int idx);
    int o = idx % 8;
    case (idx / 8)
      0:       return (idx == 0) ? 32'd0 : m_glob[o];
      1:       return m_in[(m_win + 7) % 8][o];
      2:       return m_loc[m_win][o];
      default: return m_in[m_win][o];
    endcase
  endfunction

  task automatic model_wr(int idx, logic [31:0] v);
    int o = idx % 8;
    case (idx / 8)
      0:       if (idx != 0) m_glob[o] = v;
      1:       m_in[(m_win + 7) % 8][o] = v;
      2:       m_loc[m_win][o] = v;
      default: m_in[m_win][o] = v;
    endcase
  endtask

  function automatic string cls(int idx);
    if (idx == 0) return "R1";
    if (idx < 8)  return "R2";
    if (idx < 16) return "R4";
    if (idx < 24) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive, compare outputs against model, then advance model
  task automatic step(int ra, int rb, bit we, int wi, logic [31:0] wd,
                      bit sv, bit rs, string tag);
    @(negedge clk);
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    save_i = sv; restore_i = rs;
    #1;
    chk((tag == "") ? cls(ra) : tag, rd_a_data, model_rd(ra));
    chk((tag == "") ? "R12" : tag, rd_b_data, model_rd(rb));
    chk("R8", {31'd0, ovf_o}, {31'd0, m_ovf});
    chk("R9", {31'd0, unf_o}, {31'd0, m_unf});
    @(posedge clk);
    if (we) model_wr(wi, wd);   // R6: old window
    m_ovf = 0; m_unf = 0;
    if (sv && !rs) begin
      if (m_depth == 6) m_ovf = 1;
      else begin m_win = (m_win + 7) % 8; m_depth++; end
    end else if (rs && !sv) begin
      if (m_depth == 0) m_unf = 1;
      else begin m_win = (m_win + 1) % 8; m_depth--; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 0; save_i = 0; restore_i = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // R11: everything zero after reset, flags low
    for (int i = 0; i < 32; i++) step(i, 31 - i, 0, 0, 0, 0, 0, "R11");

    // R1: write to index 0 discarded
    step(0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, "R1");

    // R2 / R4 / R3 set-up in window 0
    for (int i = 1; i < 32; i++) step(0, i, 1, i, 32'h1000_0000 + i, 0, 0, "");
    // R5: save from window 0 wraps to 7; outs become ins (R4)
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    for (int i = 24; i < 32; i++) step(i, i - 16, 0, 0, 0, 0, 0, "R4");
    for (int i = 1; i < 8; i++)   step(i, 16 + i, 0, 0, 0, 0, 0, "R2");
    // R3: new window's locals untouched by caller; write them, return
    for (int i = 16; i < 24; i++) step(i, i, 1, i, 32'h2000_0000 + i, 0, 0, "R3");
    for (int i = 24; i < 32; i++) step(0, 0, 1, i, 32'h3000_0000 + i, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, "R5");
    for (int i = 16; i < 24; i++) step(i, i - 8, 0, 0, 0, 0, 0, "R3");

    // R7: same-cycle read of written register returns old value
    step(20, 20, 1, 20, 32'hCAFE_0020, 0, 0, "R7");
    step(20, 20, 0, 0, 0, 0, 0, "R7");

    // R6: write coincident with save lands in the old window
    step(0, 0, 1, 17, 32'h6666_0017, 1, 0, "R6");
    step(17, 17, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 18, 32'h6666_1018, 0, 1, "R6");
    step(18, 17, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 0, "R6");
    step(18, 17, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, "R5");

    // R10: simultaneous save and restore ignored
    step(0, 0, 0, 0, 0, 1, 1, "R10");
    step(17, 18, 0, 0, 0, 0, 0, "R10");

    // R9: restore with nothing resident
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    step(16, 17, 0, 0, 0, 0, 0, "R9");
    step(16, 17, 0, 0, 0, 0, 0, "R9");

    // R8: six accepted saves, seventh refused
    for (int k = 0; k < 6; k++) step(16, 24, 1, 16, 32'h8000_0000 + k, 1, 0, "R8");
    step(16, 24, 0, 0, 0, 1, 0, "R8");
    step(16, 8, 0, 0, 0, 0, 0, "R8");
    step(16, 8, 0, 0, 0, 0, 0, "R8");
    for (int k = 0; k < 7; k++) step(16, 24, 0, 0, 0, 0, 1, "R9");
    step(16, 24, 0, 0, 0, 0, 0, "R9");

    // Random traffic: model compared every clock (R12 on port B)
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 16;
      step($urandom % 32, $urandom % 32, ($urandom % 2) == 1, $urandom % 32,
           $urandom, r == 0 || r == 2, r == 1 || r == 2, "");
    end

    // R11: reset mid-run clears all state
    do_reset();
    for (int i = 0; i < 32; i++) step(i, (i + 8) % 32, 0, 0, 0, 0, 0, "R11");

    summary();
    $finish;
  end

endmodule